// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block owns the program counter of a 32-bit RISC core whose instructions are one aligned word each. Every cycle it looks at the instruction presented with the current PC. It also takes three register values read by the register file: the two compare operands and the jump-target register. From these it works out the address of the next instruction. On a clock edge with a valid instruction it loads that address into the PC.

It handles conditional compare-and-branch, PC-relative jump, PC-relative call, jump through a register and call through a register. Both call kinds ask for the return address (PC + 4) to be written into the fixed link register. A jump through the exception-link register or the breakpoint-link register is flagged as a return, so that the core can restore its interrupt-enable state. A target that is not word aligned raises a fault and leaves the PC unchanged. Exception vectoring and pipeline flushing belong to other blocks.

The major opcode sits in instruction bits 31:26. The first register index sits in bits 25:21 and the second in bits 20:16. A short immediate occupies bits 15:0 and a long immediate occupies bits 25:0.

Top module: `bru_nextpc`

## Requirements
- R1: After synchronous reset the PC output equals the parameter RESET_PC (default 0x0000_1000).
- R2: Any opcode other than the ten listed in R3, R5, R6 and R7 gives next PC = PC + 4, taken low, and no link write.
- R3: Opcodes 0x11 (equal), 0x17 (not equal), 0x12 (signed greater), 0x13 (signed greater-or-equal), 0x15 (unsigned greater) and 0x14 (unsigned greater-or-equal) compare operand A with operand B. When the condition holds, taken is high and next PC = PC + sign-extended bits 15:0 times 4.
- R4: When the condition of an R3 branch fails, next PC = PC + 4 and taken is low.
- R5: Opcode 0x38 is a relative jump: taken is high and next PC = PC + sign-extended bits 25:0 times 4, with no link write.
- R6: Opcode 0x3E is a relative call. Its target is the same as in R5, and it also writes PC + 4 to link register index 29.
- R7: Opcode 0x30 (register jump) and opcode 0x36 (register call) set next PC to the jump-register value, with taken high. Only 0x36 writes PC + 4 to index 29.
- R8: A register jump (0x30) whose bits 25:21 equal 30 raises the exception-return flag, and one whose bits 25:21 equal 31 raises the breakpoint-return flag. A register call never raises either flag.
- R9: A taken target whose two low bits are not zero raises the alignment fault. In that case next PC = PC, taken, link write and both return flags stay low, and the PC holds across the clock edge.
- R10: The PC loads next PC on a clock edge only when instruction-valid is high. With it low, all flags stay low and the PC holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction on `instr` is to be executed this cycle |
| instr | input | 32 | Instruction word |
| opa | input | 32 | Value of register at bits 25:21 (compare operand A) |
| opb | input | 32 | Value of register at bits 20:16 (compare operand B) |
| jreg | input | 32 | Value of register at bits 25:21 (jump target) |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address the PC loads at the next valid edge |
| taken_o | output | 1 | Control flow leaves the sequential path |
| link_we_o | output | 1 | Write link register this cycle |
| link_idx_o | output | 5 | Index of link register written |
| link_data_o | output | 32 | Return address to write |
| exc_ret_o | output | 1 | Jump is an exception return |
| brk_ret_o | output | 1 | Jump is a breakpoint return |
| align_fault_o | output | 1 | Taken target is not word aligned |

## Verification
The assertions assume that `instr`, `opa`, `opb` and `jreg` are stable for the whole cycle they are sampled in. They also assume that RESET_PC is word aligned, because the aligned-PC property rests on both. The bench changes inputs only on the falling clock edge, and it checks combinational outputs one nanosecond later. Misaligned values appear only on `jreg`, since relative targets are aligned whenever the PC is. This keeps every PC the bench produces a multiple of four.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int XLEN   = 32;
    localparam int OP_W   = 6;
    localparam int RIDX_W = 5;
    localparam int IMMS_W = 16;
    localparam int IMML_W = 26;

    localparam logic [OP_W-1:0] OP_BEQ   = 6'h11;
    localparam logic [OP_W-1:0] OP_BGTS  = 6'h12;
    localparam logic [OP_W-1:0] OP_BGES  = 6'h13;
    localparam logic [OP_W-1:0] OP_BGEU  = 6'h14;
    localparam logic [OP_W-1:0] OP_BGTU  = 6'h15;
    localparam logic [OP_W-1:0] OP_BNEQ  = 6'h17;
    localparam logic [OP_W-1:0] OP_JREG  = 6'h30;
    localparam logic [OP_W-1:0] OP_CREG  = 6'h36;
    localparam logic [OP_W-1:0] OP_JREL  = 6'h38;
    localparam logic [OP_W-1:0] OP_CREL  = 6'h3E;

    typedef enum logic [1:0] {
        FLOW_SEQ,
        FLOW_COND,
        FLOW_REL,
        FLOW_REG
    } flow_e;

    typedef enum logic [2:0] {
        CMP_EQ,
        CMP_NE,
        CMP_GTS,
        CMP_GES,
        CMP_GTU,
        CMP_GEU
    } cmp_e;

    typedef struct packed {
        flow_e             flow;
        cmp_e              cmp;
        logic              link;
        logic [RIDX_W-1:0] ridx;
        logic [XLEN-1:0]   offset;
    } ctl_t;

    // Sign-extend an immediate of width W and scale it by one word
    function automatic logic [XLEN-1:0] word_offset(input logic [IMML_W-1:0] imm,
                                                    input int unsigned w);
        logic [XLEN-1:0] v;
        v = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (i < 2)
                v[i] = 1'b0;
            else if (i - 2 < int'(w))
                v[i] = imm[i-2];
            else
                v[i] = imm[w-1];
        end
        return v;
    endfunction

endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctl_t            ctl
);
    logic [OP_W-1:0]   op;
    logic [IMML_W-1:0] imm_long;
    logic [IMML_W-1:0] imm_short;

    assign op        = instr[XLEN-1 -: OP_W];
    assign imm_long  = instr[IMML_W-1:0];
    assign imm_short = {{(IMML_W-IMMS_W){1'b0}}, instr[IMMS_W-1:0]};

    always_comb begin
        ctl.flow   = FLOW_SEQ;
        ctl.cmp    = CMP_EQ;
        ctl.link   = 1'b0;
        ctl.ridx   = instr[IMML_W-1 -: RIDX_W];
        ctl.offset = word_offset(imm_short, IMMS_W);
        unique case (op)
            OP_BEQ:  begin ctl.flow = FLOW_COND; ctl.cmp = CMP_EQ;  end
            OP_BNEQ: begin ctl.flow = FLOW_COND; ctl.cmp = CMP_NE;  end
            OP_BGTS: begin ctl.flow = FLOW_COND; ctl.cmp = CMP_GTS; end
            OP_BGES: begin ctl.flow = FLOW_COND; ctl.cmp = CMP_GES; end
            OP_BGTU: begin ctl.flow = FLOW_COND; ctl.cmp = CMP_GTU; end
            OP_BGEU: begin ctl.flow = FLOW_COND; ctl.cmp = CMP_GEU; end
            OP_JREL: begin
                ctl.flow   = FLOW_REL;
                ctl.offset = word_offset(imm_long, IMML_W);
            end
            OP_CREL: begin
                ctl.flow   = FLOW_REL;
                ctl.link   = 1'b1;
                ctl.offset = word_offset(imm_long, IMML_W);
            end
            OP_JREG: ctl.flow = FLOW_REG;
            OP_CREG: begin
                ctl.flow = FLOW_REG;
                ctl.link = 1'b1;
            end
            default: ctl.flow = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/bru_compare.sv
module bru_compare
    import bru_pkg::*;
(
    input  cmp_e            cmp,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            hit
);
    logic eq, gts, gtu;

    assign eq  = (a == b);
    assign gts = ($signed(a) > $signed(b));
    assign gtu = (a > b);

    always_comb begin
        unique case (cmp)
            CMP_EQ:  hit = eq;
            CMP_NE:  hit = !eq;
            CMP_GTS: hit = gts;
            CMP_GES: hit = gts | eq;
            CMP_GTU: hit = gtu;
            CMP_GEU: hit = gtu | eq;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
(
    input  ctl_t            ctl,
    input  logic            cond_hit,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] jreg,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] seq_pc,
    output logic            take
);
    logic [XLEN-1:0] rel_pc;

    assign seq_pc = pc + XLEN'(4);
    assign rel_pc = pc + ctl.offset;

    always_comb begin
        unique case (ctl.flow)
            FLOW_COND: begin
                take   = cond_hit;
                target = cond_hit ? rel_pc : seq_pc;
            end
            FLOW_REL: begin
                take   = 1'b1;
                target = rel_pc;
            end
            FLOW_REG: begin
                take   = 1'b1;
                target = jreg;
            end
            default: begin
                take   = 1'b0;
                target = seq_pc;
            end
        endcase
    end
endmodule

// File: rtl/bru_nextpc.sv
module bru_nextpc
    import bru_pkg::*;
#(
    parameter logic [XLEN-1:0]   RESET_PC = 32'h0000_1000,
    parameter logic [RIDX_W-1:0] LINK_REG = 5'd29,
    parameter logic [RIDX_W-1:0] EXC_REG  = 5'd30,
    parameter logic [RIDX_W-1:0] BRK_REG  = 5'd31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [XLEN-1:0]   instr,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    input  logic [XLEN-1:0]   jreg,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              taken_o,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_idx_o,
    output logic [XLEN-1:0]   link_data_o,
    output logic              exc_ret_o,
    output logic              brk_ret_o,
    output logic              align_fault_o
);
    ctl_t            ctl;
    logic            cond_hit;
    logic            take;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] pc_q;
    logic            misaligned;
    logic            commit;
    logic            plain_jump;

    bru_decode u_dec (
        .instr (instr),
        .ctl   (ctl)
    );

    bru_compare u_cmp (
        .cmp (ctl.cmp),
        .a   (opa),
        .b   (opb),
        .hit (cond_hit)
    );

    bru_target u_tgt (
        .ctl      (ctl),
        .cond_hit (cond_hit),
        .pc       (pc_q),
        .jreg     (jreg),
        .target   (target),
        .seq_pc   (seq_pc),
        .take     (take)
    );

    assign misaligned = instr_valid && take && (target[1:0] != 2'b00);
    assign commit     = instr_valid && !misaligned;
    assign plain_jump = commit && (ctl.flow == FLOW_REG) && !ctl.link;

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_PC;
        else if (commit)
            pc_q <= target;
    end

    assign pc_o          = pc_q;
    assign next_pc_o     = commit ? target : pc_q;
    assign taken_o       = commit && take;
    assign link_we_o     = commit && ctl.link;
    assign link_idx_o    = LINK_REG;
    assign link_data_o   = seq_pc;
    assign exc_ret_o     = plain_jump && (ctl.ridx == EXC_REG);
    assign brk_ret_o     = plain_jump && (ctl.ridx == BRK_REG);
    assign align_fault_o = misaligned;
endmodule

// File: rtl/bru_nextpc_chk.sv
module bru_nextpc_chk
    import bru_pkg::*;
#(
    parameter logic [RIDX_W-1:0] LINK_REG = 5'd29
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic [XLEN-1:0]   pc_o,
    input logic [XLEN-1:0]   next_pc_o,
    input logic              taken_o,
    input logic              link_we_o,
    input logic [RIDX_W-1:0] link_idx_o,
    input logic [XLEN-1:0]   link_data_o,
    input logic              exc_ret_o,
    input logic              brk_ret_o,
    input logic              align_fault_o
);
    // R10
    pc_follows_next_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> pc_o == $past(next_pc_o));

    // R10
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(pc_o));

    // R9
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        align_fault_o |-> (next_pc_o == pc_o) && !taken_o && !link_we_o
                          && !exc_ret_o && !brk_ret_o);

    // R9
    pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        pc_o[1:0] == 2'b00);

    // R6
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (link_data_o == pc_o + XLEN'(4)) && (link_idx_o == LINK_REG));

    // R8
    ret_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exc_ret_o, brk_ret_o}));

    // R8
    ret_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_ret_o || brk_ret_o) |-> taken_o && !link_we_o);

    // R4
    not_taken_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !taken_o && !align_fault_o) |-> next_pc_o == pc_o + XLEN'(4));
endmodule

bind bru_nextpc bru_nextpc_chk #(.LINK_REG(LINK_REG)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_valid   (instr_valid),
    .pc_o          (pc_o),
    .next_pc_o     (next_pc_o),
    .taken_o       (taken_o),
    .link_we_o     (link_we_o),
    .link_idx_o    (link_idx_o),
    .link_data_o   (link_data_o),
    .exc_ret_o     (exc_ret_o),
    .brk_ret_o     (brk_ret_o),
    .align_fault_o (align_fault_o)
);

// File: tb/bru_nextpc_test.sv
module bru_nextpc_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] jreg = '0;
    logic [31:0] pc_o, next_pc_o, link_data_o;
    logic        taken_o, link_we_o, exc_ret_o, brk_ret_o, align_fault_o;
    logic [4:0]  link_idx_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] mpc;
    bit finished = 0;

    always #4 clk = ~clk;

    bru_nextpc uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .opa(opa), .opb(opb), .jreg(jreg), .pc_o(pc_o), .next_pc_o(next_pc_o),
        .taken_o(taken_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
        .link_data_o(link_data_o), .exc_ret_o(exc_ret_o), .brk_ret_o(brk_ret_o),
        .align_fault_o(align_fault_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ins_cmp(input logic [5:0] op, input logic [15:0] imm);
        return {op, 5'd1, 5'd2, imm};
    endfunction

    function automatic logic [31:0] ins_long(input logic [5:0] op, input logic [25:0] imm);
        return {op, imm};
    endfunction

    function automatic logic [31:0] ins_reg(input logic [5:0] op, input logic [4:0] r);
        return {op, r, 21'd0};
    endfunction

    // Drive one instruction, check combinational outputs, clock, check PC
    task automatic run_op(input string req, input logic v, input logic [31:0] ins,
                          input logic [31:0] a, input logic [31:0] b, input logic [31:0] j,
                          input logic [31:0] exp_next, input logic exp_take,
                          input logic exp_link, input logic exp_er, input logic exp_br,
                          input logic exp_fault);
        instr_valid = v; instr = ins; opa = a; opb = b; jreg = j;
        #1;
        chk(req, "next_pc", next_pc_o, exp_next);
        chk(req, "taken", 32'(taken_o), 32'(exp_take));
        chk(req, "link_we", 32'(link_we_o), 32'(exp_link));
        if (exp_link) begin
            chk(req, "link_data", link_data_o, mpc + 32'd4);
            chk(req, "link_idx", 32'(link_idx_o), 32'd29);
        end
        chk(req, "exc_ret", 32'(exc_ret_o), 32'(exp_er));
        chk(req, "brk_ret", 32'(brk_ret_o), 32'(exp_br));
        chk(req, "align_fault", 32'(align_fault_o), 32'(exp_fault));
        @(posedge clk);
        @(negedge clk);
        chk(req, "pc after edge", pc_o, exp_next);
        mpc = exp_next;
        instr_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        mpc = 32'h0000_1000;
        chk("R1", "pc after reset", pc_o, 32'h0000_1000);
    endtask

    task automatic t_sequential;
        run_op("R2", 1, ins_cmp(6'h0D, 16'h0010), 5, 5, 32'h8000_0000,
               mpc + 4, 0, 0, 0, 0, 0);
        run_op("R2", 1, ins_reg(6'h31, 5'd30), 0, 0, 32'h0000_0002,
               mpc + 4, 0, 0, 0, 0, 0);
    endtask

    task automatic t_equal_branches;
        run_op("R3", 1, ins_cmp(6'h11, 16'h0003), 7, 7, 0, mpc + 12, 1, 0, 0, 0, 0);
        run_op("R4", 1, ins_cmp(6'h11, 16'h0003), 7, 8, 0, mpc + 4, 0, 0, 0, 0, 0);
        run_op("R3", 1, ins_cmp(6'h17, 16'hFFFF), 1, 2, 0, mpc - 4, 1, 0, 0, 0, 0);
        run_op("R4", 1, ins_cmp(6'h17, 16'h0040), 9, 9, 0, mpc + 4, 0, 0, 0, 0, 0);
    endtask

    task automatic t_magnitude_branches;
        // -1 vs 1: signed greater fails, unsigned greater holds
        run_op("R4", 1, ins_cmp(6'h12, 16'h0008), 32'hFFFF_FFFF, 1, 0,
               mpc + 4, 0, 0, 0, 0, 0);
        run_op("R3", 1, ins_cmp(6'h15, 16'h0008), 32'hFFFF_FFFF, 1, 0,
               mpc + 32, 1, 0, 0, 0, 0);
        run_op("R3", 1, ins_cmp(6'h13, 16'h0002), 32'h8000_0000, 32'h8000_0000, 0,
               mpc + 8, 1, 0, 0, 0, 0);
        run_op("R4", 1, ins_cmp(6'h14, 16'h0002), 1, 2, 0, mpc + 4, 0, 0, 0, 0, 0);
        run_op("R4", 1, ins_cmp(6'h13, 16'h0002), 32'h8000_0000, 0, 0,
               mpc + 4, 0, 0, 0, 0, 0);
        run_op("R3", 1, ins_cmp(6'h14, 16'h8000), 32'h8000_0000, 0, 0,
               mpc - 32'h0002_0000, 1, 0, 0, 0, 0);
    endtask

    task automatic t_relative;
        run_op("R5", 1, ins_long(6'h38, 26'h3FF_FFFE), 0, 0, 0, mpc - 8, 1, 0, 0, 0, 0);
        run_op("R6", 1, ins_long(6'h3E, 26'h000_0010), 0, 0, 0, mpc + 64, 1, 1, 0, 0, 0);
    endtask

    task automatic t_register;
        run_op("R7", 1, ins_reg(6'h30, 5'd5), 0, 0, 32'h0000_2000,
               32'h0000_2000, 1, 0, 0, 0, 0);
        run_op("R8", 1, ins_reg(6'h30, 5'd30), 0, 0, 32'h0000_3000,
               32'h0000_3000, 1, 0, 1, 0, 0);
        run_op("R8", 1, ins_reg(6'h30, 5'd31), 0, 0, 32'h0000_4000,
               32'h0000_4000, 1, 0, 0, 1, 0);
        run_op("R7", 1, ins_reg(6'h36, 5'd30), 0, 0, 32'h0000_5000,
               32'h0000_5000, 1, 1, 0, 0, 0);
    endtask

    task automatic t_misaligned;
        run_op("R9", 1, ins_reg(6'h30, 5'd30), 0, 0, 32'h0000_6002,
               mpc, 0, 0, 0, 0, 1);
        run_op("R9", 1, ins_reg(6'h36, 5'd7), 0, 0, 32'h0000_6001,
               mpc, 0, 0, 0, 0, 1);
    endtask

    task automatic t_idle;
        run_op("R10", 0, ins_cmp(6'h11, 16'h0010), 3, 3, 0, mpc, 0, 0, 0, 0, 0);
        run_op("R10", 0, ins_reg(6'h36, 5'd31), 0, 0, 32'h0000_7000,
               mpc, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sequential();
        t_equal_branches();
        t_magnitude_branches();
        t_relative();
        t_register();
        t_misaligned();
        t_idle();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule